// File: doc/BRIEF.md
# Stride prefetch address generator

This block turns one training decision into a short burst of prefetch candidate addresses. A trigger carries a base address, a signed stride in bytes and a burst length (the degree). Once the block accepts the trigger, it presents candidates on a valid/ready output, one per cycle while the consumer is ready. Candidate d is the base plus d times an effective stride. A stride whose magnitude is under one cache block is widened to one block, and its direction is kept.

The burst ends early at the first candidate whose page differs from the base address's page. That candidate and every later one are discarded, and a running counter adds the number discarded. While a burst is in progress the block raises busy, and it ignores any trigger presented during that time. Queueing of the candidates, duplicate filtering and issue to memory belong to the consumer.

Top module: `stride_pf_gen`

## Requirements
- R1: After reset, pf_valid, busy and drop_count are all zero.
- R2: For d = 1 up to the degree, candidate d is base + d × effective stride, computed modulo 2^ADDR_W. Candidates leave in increasing order of d.
- R3: trig_stride is two's complement. If -BLK_BYTES < stride < BLK_BYTES, the effective stride is +BLK_BYTES for a stride of zero or more and -BLK_BYTES for a negative stride. Any other stride is used unchanged.
- R4: A candidate is presented only if its address bits above log2(PAGE_BYTES) equal those of the base address.
- R5: At the first candidate that fails R4, the burst ends, and neither that candidate nor any later one for the same trigger is presented.
- R6: When a burst ends at step d through R5, drop_count increases by degree − d + 1. The increase appears on the clock edge after that candidate becomes current, and busy falls on the same edge.
- R7: pf_prio is zero whenever pf_valid is high.
- R8: A trigger (trig_valid high with busy low at a rising edge) sets busy. Busy stays high until the burst ends. A trigger presented while busy is high has no effect on the burst or on later outputs.
- R9: While pf_valid is high and pf_ready is low, pf_valid stays high and pf_addr holds its value at the next edge.
- R10: The degree is sampled when the trigger is accepted. Later changes of trig_degree do not alter the burst. A degree of zero leaves busy and pf_valid low.
- R11: The first candidate is presented in the cycle after the accepting edge. With pf_ready held high, one candidate leaves per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger request |
| trig_base | input | ADDR_W | Base address of the burst |
| trig_stride | input | STRIDE_W | Signed stride in bytes |
| trig_degree | input | DEG_W | Number of candidates wanted |
| busy | output | 1 | A burst is in progress |
| pf_valid | output | 1 | Candidate address is valid |
| pf_ready | input | 1 | Consumer takes the candidate |
| pf_addr | output | ADDR_W | Candidate address |
| pf_prio | output | PRIO_W | Candidate priority, always zero |
| drop_count | output | DROP_W | Running total of candidates discarded at page crossings |

## Verification
A trigger is accepted at a rising edge. The first candidate is on the output one register later, so the bench reads it at the following falling edge. Each later candidate follows one edge after a handshake. When a candidate crosses the page, its valid stays low, and drop_count and busy change on the next edge. The bench therefore waits for busy to drop and only then compares the counter with its own model. All outputs are sampled, and pf_ready is driven, at falling edges, so every handshake the bench counts is the one the design sees at the next rising edge.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;

   typedef enum logic [0:0] {
      SQ_IDLE = 1'b0,
      SQ_RUN  = 1'b1
   } seq_state_e;

endpackage

// File: rtl/pf_stride_round.sv
module pf_stride_round #(
   parameter int ADDR_W    = 32,
   parameter int STRIDE_W  = 16,
   parameter int BLK_BYTES = 64
) (
   input  logic [STRIDE_W-1:0] stride_i,
   output logic [ADDR_W-1:0]   eff_o
);

   localparam logic signed [STRIDE_W-1:0] BLK_POS = STRIDE_W'(BLK_BYTES);
   localparam logic signed [STRIDE_W-1:0] BLK_NEG = -BLK_POS;

   logic signed [STRIDE_W-1:0] s_in;
   logic signed [STRIDE_W-1:0] s_rnd;
   logic                       is_small;

   always_comb begin
      s_in     = $signed(stride_i);
      is_small = (s_in < BLK_POS) && (s_in > BLK_NEG);
      if (!is_small)
         s_rnd = s_in;
      else if (s_in[STRIDE_W-1])
         s_rnd = BLK_NEG;
      else
         s_rnd = BLK_POS;
   end

   // widen to address width: variant picked by relative widths
   generate
      if (ADDR_W == STRIDE_W) begin : g_same_w
         assign eff_o = s_rnd;
      end else begin : g_sext
         assign eff_o = {{(ADDR_W-STRIDE_W){s_rnd[STRIDE_W-1]}}, s_rnd};
      end
   endgenerate

endmodule

// File: rtl/pf_page_cmp.sv
module pf_page_cmp #(
   parameter int ADDR_W     = 32,
   parameter int PAGE_BYTES = 4096
) (
   input  logic [ADDR_W-1:0] addr_a_i,
   input  logic [ADDR_W-1:0] addr_b_i,
   output logic              same_o
);

   localparam int PG_LOG = $clog2(PAGE_BYTES);

   logic [ADDR_W-1:0] diff;

   always_comb begin
      diff   = addr_a_i ^ addr_b_i;
      same_o = ((diff >> PG_LOG) == '0);
   end

endmodule

// File: rtl/pf_burst_seq.sv
module pf_burst_seq
   import stride_pf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DEG_W  = 4,
   parameter int DROP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] eff_i,
   input  logic [DEG_W-1:0]  deg_i,
   input  logic              in_page_i,
   input  logic              ready_i,
   output logic              busy_o,
   output logic              valid_o,
   output logic [ADDR_W-1:0] cand_o,
   output logic [ADDR_W-1:0] base_o,
   output logic [DROP_W-1:0] drop_o
);

   seq_state_e        state_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] eff_q;
   logic [ADDR_W-1:0] cand_q;
   logic [DEG_W-1:0]  step_q;
   logic [DEG_W-1:0]  deg_q;
   logic [DROP_W-1:0] drop_q;
   logic [DEG_W:0]    remain;
   logic              last_step;
   logic              run;

   assign run       = (state_q == SQ_RUN);
   assign last_step = (step_q == deg_q);
   assign remain    = {1'b0, deg_q} - {1'b0, step_q} + (DEG_W+1)'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         base_q  <= '0;
         eff_q   <= '0;
         cand_q  <= '0;
         step_q  <= '0;
         deg_q   <= '0;
         drop_q  <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (start_i && (deg_i != '0)) begin
                  state_q <= SQ_RUN;
                  base_q  <= base_i;
                  eff_q   <= eff_i;
                  cand_q  <= base_i + eff_i;
                  step_q  <= DEG_W'(1);
                  deg_q   <= deg_i;
               end
            end
            default: begin
               if (!in_page_i) begin
                  drop_q  <= drop_q + DROP_W'(remain);
                  state_q <= SQ_IDLE;
               end else if (ready_i) begin
                  if (last_step) begin
                     state_q <= SQ_IDLE;
                  end else begin
                     cand_q <= cand_q + eff_q;
                     step_q <= step_q + DEG_W'(1);
                  end
               end
            end
         endcase
      end
   end

   assign busy_o  = run;
   assign valid_o = run && in_page_i;
   assign cand_o  = cand_q;
   assign base_o  = base_q;
   assign drop_o  = drop_q;

   // step index stays within 1..degree during a burst
   p_step_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (step_q != '0) && (step_q <= deg_q));

   // counter moves only on the edge that ends a burst
   p_drop_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drop_q) |-> (state_q == SQ_IDLE) && $past(run));

   // a trigger during a burst leaves the latched base alone
   p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && start_i) |=> $stable(base_q));

endmodule

// File: rtl/stride_pf_gen.sv
module stride_pf_gen #(
   parameter int ADDR_W     = 32,
   parameter int STRIDE_W   = 16,
   parameter int DEG_W      = 4,
   parameter int DROP_W     = 16,
   parameter int PRIO_W     = 2,
   parameter int BLK_BYTES  = 64,
   parameter int PAGE_BYTES = 4096
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trig_valid,
   input  logic [ADDR_W-1:0]   trig_base,
   input  logic [STRIDE_W-1:0] trig_stride,
   input  logic [DEG_W-1:0]    trig_degree,
   output logic                busy,
   output logic                pf_valid,
   input  logic                pf_ready,
   output logic [ADDR_W-1:0]   pf_addr,
   output logic [PRIO_W-1:0]   pf_prio,
   output logic [DROP_W-1:0]   drop_count
);

   localparam int BLK_LOG = $clog2(BLK_BYTES);

   generate
      if ((BLK_BYTES < 1) || ((BLK_BYTES & (BLK_BYTES - 1)) != 0)) begin : g_bad_blk
         $error("BLK_BYTES must be a power of two");
      end
      if ((PAGE_BYTES < BLK_BYTES) || ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0)) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two no smaller than BLK_BYTES");
      end
      if ((STRIDE_W < BLK_LOG + 2) || (STRIDE_W > ADDR_W)) begin : g_bad_stride
         $error("STRIDE_W must hold +/-BLK_BYTES and not exceed ADDR_W");
      end
      if (DROP_W < DEG_W + 1) begin : g_bad_drop
         $error("DROP_W must exceed DEG_W");
      end
   endgenerate

   logic [ADDR_W-1:0] eff_stride;
   logic [ADDR_W-1:0] base_held;
   logic              in_page;

   pf_stride_round #(
      .ADDR_W   (ADDR_W),
      .STRIDE_W (STRIDE_W),
      .BLK_BYTES(BLK_BYTES)
   ) u_round (
      .stride_i(trig_stride),
      .eff_o   (eff_stride)
   );

   pf_page_cmp #(
      .ADDR_W    (ADDR_W),
      .PAGE_BYTES(PAGE_BYTES)
   ) u_page (
      .addr_a_i(pf_addr),
      .addr_b_i(base_held),
      .same_o  (in_page)
   );

   pf_burst_seq #(
      .ADDR_W(ADDR_W),
      .DEG_W (DEG_W),
      .DROP_W(DROP_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (trig_valid),
      .base_i   (trig_base),
      .eff_i    (eff_stride),
      .deg_i    (trig_degree),
      .in_page_i(in_page),
      .ready_i  (pf_ready),
      .busy_o   (busy),
      .valid_o  (pf_valid),
      .cand_o   (pf_addr),
      .base_o   (base_held),
      .drop_o   (drop_count)
   );

   assign pf_prio = '0;

   // stalled candidate is held
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && !pf_ready) |=> pf_valid && $stable(pf_addr));

   // zero degree never starts a burst
   p_deg_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_valid && !busy && (trig_degree == '0)) |=> !busy);

   // output valid only inside a burst
   p_valid_in_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> busy);

   // accepted trigger with nonzero degree raises busy
   p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_valid && !busy && (trig_degree != '0)) |=> busy);

endmodule

// File: tb/tb_stride_pf_gen.sv
`timescale 1ns/1ps
module tb_stride_pf_gen;

   typedef struct packed {
      logic [31:0] base;
      logic [15:0] stride;
      logic [3:0]  deg;
      logic        stall;
      logic        inject;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [0:NV-1] = '{
      '{32'h1000_0000, 16'h0080,  4'd4,  1'b0, 1'b1},
      '{32'h1000_0100, 16'h0008,  4'd3,  1'b0, 1'b0},
      '{32'h1000_0100, 16'hFFFB,  4'd3,  1'b0, 1'b0},
      '{32'h2000_0F00, 16'h0040,  4'd6,  1'b0, 1'b0},
      '{32'h2000_0040, 16'hFFC0,  4'd4,  1'b0, 1'b0},
      '{32'h3000_0000, 16'h0000,  4'd2,  1'b0, 1'b0},
      '{32'h4000_0800, 16'h1000,  4'd5,  1'b0, 1'b0},
      '{32'h5000_0000, 16'h0100,  4'd15, 1'b1, 1'b1},
      '{32'h6000_0000, 16'h003F,  4'd2,  1'b0, 1'b0},
      '{32'h7000_0800, 16'hFFBF,  4'd2,  1'b1, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_valid = 1'b0;
   logic [31:0] trig_base = '0;
   logic [15:0] trig_stride = '0;
   logic [3:0]  trig_degree = '0;
   logic        busy;
   logic        pf_valid;
   logic        pf_ready = 1'b0;
   logic [31:0] pf_addr;
   logic [1:0]  pf_prio;
   logic [15:0] drop_count;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   stride_pf_gen dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_valid (trig_valid),
      .trig_base  (trig_base),
      .trig_stride(trig_stride),
      .trig_degree(trig_degree),
      .busy       (busy),
      .pf_valid   (pf_valid),
      .pf_ready   (pf_ready),
      .pf_addr    (pf_addr),
      .pf_prio    (pf_prio),
      .drop_count (drop_count)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // model of R2/R3/R4/R5/R6
   function automatic int eff_of(input logic [15:0] s);
      int v;
      v = int'($signed(s));
      if (v < 64 && v > -64) v = (v < 0) ? -64 : 64;
      return v;
   endfunction

   task automatic run_vec(input vec_t v);
      logic [31:0] exp_a [16];
      int          n_exp = 0;
      int          drops = 0;
      int          eff;
      int          got = 0;
      int          cyc = 0;
      logic [15:0] drop0;
      bit          prev_stall = 1'b0;
      logic [31:0] prev_addr = '0;
      eff = eff_of(v.stride);
      for (int d = 1; d <= int'(v.deg); d++) begin
         logic [31:0] a;
         a = v.base + 32'(d * eff);
         if ((a >> 12) != (v.base >> 12)) begin
            drops = int'(v.deg) - d + 1;
            break;
         end
         exp_a[n_exp] = a;
         n_exp++;
      end
      drop0 = drop_count;
      @(negedge clk);
      trig_valid  = 1'b1;
      trig_base   = v.base;
      trig_stride = v.stride;
      trig_degree = v.deg;
      @(negedge clk);
      trig_valid = 1'b0;
      chk(busy == 1'b1, "R8 busy after accept", 64'(busy), 64'd1);
      while (busy && cyc < 200) begin
         logic rdy;
         rdy = v.stall ? ((cyc % 3) != 1) : 1'b1;
         pf_ready = rdy;
         if (v.inject && cyc == 1) begin
            trig_valid  = 1'b1;
            trig_base   = 32'hDEAD_0000;
            trig_stride = 16'h0200;
            trig_degree = 4'd1;
         end else begin
            trig_valid = 1'b0;
         end
         if (prev_stall) begin
            chk(pf_valid && pf_addr == prev_addr, "R9 hold while stalled", 64'(pf_addr), 64'(prev_addr));
         end
         if (pf_valid) begin
            chk(pf_prio == 2'd0, "R7 priority zero", 64'(pf_prio), 64'd0);
            if (rdy) begin
               if (!v.stall) chk(cyc == got, "R11 one per cycle", 64'(cyc), 64'(got));
               if (got < n_exp)
                  chk(pf_addr == exp_a[got], "R2/R3 candidate address", 64'(pf_addr), 64'(exp_a[got]));
               else
                  chk(1'b0, "R5 extra candidate", 64'(pf_addr), 64'd0);
               got++;
            end
         end
         prev_stall = pf_valid && !rdy;
         prev_addr  = pf_addr;
         @(negedge clk);
         cyc++;
      end
      trig_valid = 1'b0;
      pf_ready   = 1'b0;
      chk(got == n_exp, "R5 candidate count", 64'(got), 64'(n_exp));
      chk(drop_count == drop0 + 16'(drops), "R6 drop count", 64'(drop_count), 64'(drop0 + 16'(drops)));
      chk(pf_valid == 1'b0, "R4 no candidate after burst", 64'(pf_valid), 64'd0);
      @(negedge clk);
      chk(busy == 1'b0, "R8 injected trigger ignored", 64'(busy), 64'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk(pf_valid == 1'b0 && busy == 1'b0 && drop_count == '0, "R1 reset state",
          {46'd0, pf_valid, busy, drop_count}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(VEC[i]);

      // R10: degree zero produces nothing
      begin
         logic [15:0] d0;
         d0 = drop_count;
         trig_valid  = 1'b1;
         trig_base   = 32'h0800_0000;
         trig_stride = 16'h0040;
         trig_degree = 4'd0;
         @(negedge clk);
         trig_valid = 1'b0;
         chk(busy == 1'b0 && pf_valid == 1'b0, "R10 degree zero idle", {62'd0, busy, pf_valid}, 64'd0);
         chk(drop_count == d0, "R10 degree zero no drop", 64'(drop_count), 64'(d0));
      end

      // R10: degree sampled at accept, input changed afterwards
      begin
         int got = 0;
         trig_valid  = 1'b1;
         trig_base   = 32'h0900_0000;
         trig_stride = 16'h0040;
         trig_degree = 4'd2;
         pf_ready    = 1'b1;
         @(negedge clk);
         trig_valid  = 1'b0;
         trig_degree = 4'd9;
         for (int c = 0; c < 12 && busy; c++) begin
            if (pf_valid) got++;
            @(negedge clk);
         end
         pf_ready = 1'b0;
         chk(got == 2, "R10 degree latched", 64'(got), 64'd2);
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule